// File: doc/BRIEF.md
# Synchronous FIFO Controller with Mark and Retransmit

This block runs a single-clock FIFO over an internal storage array of `2**AW` words. It keeps a write pointer and a read pointer, derives the occupancy from their difference, and drives three status outputs. An input sampled during reset picks one of two output behaviours for the rest of the run. In standard mode, a word reaches the output register only when a read is requested. In fall-through mode, the oldest word is moved into the output register without any request.

The two main status outputs change meaning with that mode. `stat_a` is an empty flag in standard mode and a data-valid flag in fall-through mode. `stat_b` is a full flag in standard mode and a space-available flag in fall-through mode.

A mark pulse saves the read position. A later retransmit rewinds the read pointer to the saved position, so the same words can be read again. While a mark is held, space is counted from the mark and not from the read pointer, so marked data is never overwritten. A load-enable input must be high for any data transfer to take place.

Top module: `mark_fifo`

## Requirements
- R1: A clock edge with `rst` high clears both pointers, the mark and the output register (so `rd_data` becomes 0), and latches `fwft_sel` as the mode: 0 selects standard mode and 1 selects fall-through mode.
- R2: In standard mode, `stat_a` is high exactly when the array holds no unread word. An accepted read (`rd_en` and `ld_en` high, array not empty) loads the oldest word into `rd_data` at that clock edge.
- R3: In fall-through mode, when the output register is empty and the array holds a word, that word is loaded into `rd_data` at the next edge with no read request. `stat_a` is high while `rd_data` holds a word not yet consumed. A read (`rd_en` with `ld_en`) consumes that word.
- R4: `stat_b` is high in standard mode when the array is full. In fall-through mode it is high when the array is not full.
- R5: `half_full` is high exactly when the number of unread words in the array is greater than half of `2**AW`.
- R6: While `ld_en` is low, no word is written, read or moved into the output register.
- R7: A write while full, and a read or fall-through load while empty, are ignored. The pointers and `rd_data` do not change.
- R8: A `mark` pulse saves the current read position (the next array word to be taken). A `retx` pulse, given after a mark, reloads the read pointer from that position. In fall-through mode it also discards the word in the output register. In that cycle the retransmit takes precedence over a read and over a new mark. A `retx` before any mark is ignored.
- R9: Once a mark is held, the array counts as full when the write pointer is `2**AW` words ahead of the mark, even if the read pointer has moved past the mark.
- R10: Words come out in the order in which they were written, including when they are replayed after a retransmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| fwft_sel | input | 1 | Mode select, sampled while `rst` is high (1 = fall-through) |
| ld_en | input | 1 | Load enable; must be high for data transfers |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Output data register |
| mark | input | 1 | Save the current read position |
| retx | input | 1 | Rewind the read pointer to the saved position |
| stat_a | output | 1 | Empty (standard) or data valid (fall-through) |
| stat_b | output | 1 | Full (standard) or space available (fall-through) |
| half_full | output | 1 | Occupancy is above half the depth |

## Verification
The bench aims at these corner cases:
- filling past full and reading past empty, where a wrong design moves a pointer and corrupts or duplicates data;
- a retransmit without a prior mark, which would wrongly rewind to address zero;
- a fill after a mark, where a design that counts space from the read pointer overwrites the marked words, so a later replay returns wrong data;
- fall-through refill after a retransmit and the two-edge latency from write to output, which catch a design that loses or repeats a word;
- transfers while `ld_en` is low, which a faulty design would let through.

Random traffic in both modes is compared edge by edge against a model of the requirements.

// File: rtl/mfifo_pkg.sv
package mfifo_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    typedef struct packed {
        logic empty;
        logic full;
        logic half;
    } occ_flags_t;

endpackage

// File: rtl/mfifo_mem.sv
module mfifo_mem #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/mfifo_ptrs.sv
module mfifo_ptrs
    import mfifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic          pop,
    input  logic          mark_req,
    input  logic          retx_req,
    output logic          push_ok,
    output logic          retx_take,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output occ_flags_t    flags
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);
    localparam logic [PW-1:0] HALF_P  = PW'(1 << (AW - 1));

    logic [PW-1:0] wr_q, rd_q, mk_q;
    logic          mv_q;
    logic [PW-1:0] occ, used;

    assign occ         = wr_q - rd_q;
    assign used        = wr_q - (mv_q ? mk_q : rd_q);
    assign flags.empty = (occ == '0);
    assign flags.full  = (used == DEPTH_P);
    assign flags.half  = (occ > HALF_P);
    assign retx_take   = retx_req & mv_q;
    assign push_ok     = push_req & ~flags.full;
    assign waddr       = wr_q[AW-1:0];
    assign raddr       = rd_q[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= '0;
            rd_q <= '0;
            mk_q <= '0;
            mv_q <= 1'b0;
        end else begin
            if (push_ok) wr_q <= wr_q + 1'b1;
            if (retx_take)  rd_q <= mk_q;
            else if (pop)   rd_q <= rd_q + 1'b1;
            if (mark_req && !retx_take) begin
                mk_q <= rd_q;
                mv_q <= 1'b1;
            end
        end
    end

    // R7 / R9: the space counted from the protected base never exceeds the depth
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        used <= DEPTH_P);
    // R7: a write while full leaves the write pointer in place
    p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (flags.full && push_req) |=> $stable(wr_q));
    // R7: the output stage never pops an empty array
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> !flags.empty);
    // R8: a retransmit restores the saved position
    p_retx_restore_r8: assert property (@(posedge clk) disable iff (rst)
        retx_take |=> (rd_q == $past(mk_q)));
endmodule

// File: rtl/mfifo_out.sv
module mfifo_out
    import mfifo_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_mode_e    mode,
    input  logic          ld_en,
    input  logic          rd_en,
    input  logic          empty,
    input  logic          retx_take,
    input  logic [DW-1:0] mem_data,
    output logic          pop,
    output logic [DW-1:0] data_q,
    output logic          valid_q
);
    logic rd_req;
    logic want;

    assign rd_req = rd_en & ld_en;
    assign want   = (mode == MODE_FWFT) ? (~valid_q | rd_en) : rd_en;
    assign pop    = ld_en & ~retx_take & ~empty & want;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (pop) data_q <= mem_data;
            if (mode == MODE_FWFT) begin
                if (retx_take)   valid_q <= 1'b0;
                else if (pop)    valid_q <= 1'b1;
                else if (rd_req) valid_q <= 1'b0;
            end else begin
                valid_q <= 1'b0;
            end
        end
    end

    // R1: output register reads zero straight after reset
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (data_q == '0));
    // R3: fall-through fills an idle output register
    p_fall_through_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWFT && !valid_q && !empty && !retx_take && ld_en) |=> valid_q);
    // R2: standard mode never marks the output register valid
    p_std_no_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STD) |-> !valid_q);
endmodule

// File: rtl/mark_fifo.sv
module mark_fifo
    import mfifo_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft_sel,
    input  logic          ld_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          mark,
    input  logic          retx,
    output logic          stat_a,
    output logic          stat_b,
    output logic          half_full
);
    fifo_mode_e    mode_q;
    occ_flags_t    flags;
    logic          push_ok, retx_take, pop, out_valid;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] mem_data;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= fifo_mode_e'(fwft_sel);
    end

    mfifo_ptrs #(.AW(AW)) u_ptrs (
        .clk       (clk),
        .rst       (rst),
        .push_req  (wr_en & ld_en),
        .pop       (pop),
        .mark_req  (mark),
        .retx_req  (retx),
        .push_ok   (push_ok),
        .retx_take (retx_take),
        .waddr     (waddr),
        .raddr     (raddr),
        .flags     (flags)
    );

    mfifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (push_ok),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_data)
    );

    mfifo_out #(.DW(DW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q),
        .ld_en     (ld_en),
        .rd_en     (rd_en),
        .empty     (flags.empty),
        .retx_take (retx_take),
        .mem_data  (mem_data),
        .pop       (pop),
        .data_q    (rd_data),
        .valid_q   (out_valid)
    );

    assign stat_a    = (mode_q == MODE_FWFT) ? out_valid : flags.empty;
    assign stat_b    = (mode_q == MODE_FWFT) ? ~flags.full : flags.full;
    assign half_full = flags.half;

    // R6: with load enable low and no rewind, nothing visible moves
    p_ld_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !retx) |=> ($stable(rd_data) && $stable(half_full)));
endmodule

// File: tb/mark_fifo_tb.sv
module mark_fifo_tb;
    localparam int DW    = 16;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int MASK  = 2 * DEPTH - 1;

    logic          clk = 1'b0;
    logic          rst, fwft_sel, ld_en, wr_en, rd_en, mark, retx;
    logic [DW-1:0] wr_data, rd_data;
    logic          stat_a, stat_b, half_full;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // model state
    logic [DW-1:0] m_mem [DEPTH];
    int            m_wr, m_rd, m_mk;
    bit            m_mv, m_ov, m_mode;
    logic [DW-1:0] m_dout;

    always #2 clk = ~clk;

    mark_fifo #(.DW(DW), .AW(AW)) u_dut (
        .clk(clk), .rst(rst), .fwft_sel(fwft_sel), .ld_en(ld_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .mark(mark), .retx(retx), .stat_a(stat_a), .stat_b(stat_b),
        .half_full(half_full)
    );

    function automatic int m_occ();
        return (m_wr - m_rd) & MASK;
    endfunction
    function automatic bit m_full();
        return ((m_wr - (m_mv ? m_mk : m_rd)) & MASK) == DEPTH;
    endfunction
    function automatic bit exp_a();
        return m_mode ? m_ov : (m_occ() == 0);
    endfunction
    function automatic bit exp_b();
        return m_mode ? !m_full() : m_full();
    endfunction
    function automatic bit exp_hf();
        return m_occ() > DEPTH / 2;
    endfunction

    task automatic model_edge();
        bit rt, pop, push, empty;
        int old_rd;
        if (rst) begin
            m_wr = 0; m_rd = 0; m_mk = 0; m_mv = 0; m_ov = 0;
            m_dout = '0; m_mode = fwft_sel;
            return;
        end
        empty  = (m_occ() == 0);
        rt     = retx && m_mv;
        pop    = ld_en && !rt && !empty && (m_mode ? (!m_ov || rd_en) : rd_en);
        push   = wr_en && ld_en && !m_full();
        old_rd = m_rd;
        if (m_mode) begin
            if (rt)                  m_ov = 0;
            else if (pop)            m_ov = 1;
            else if (rd_en && ld_en) m_ov = 0;
        end
        if (pop) m_dout = m_mem[m_rd % DEPTH];
        if (push) begin
            m_mem[m_wr % DEPTH] = wr_data;
            m_wr = (m_wr + 1) & MASK;
        end
        if (rt)       m_rd = m_mk;
        else if (pop) m_rd = (m_rd + 1) & MASK;
        if (mark && !rt) begin
            m_mk = old_rd;
            m_mv = 1;
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (phase %s) actual=%h expected=%h t=%0t", req, phase, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(m_mode ? "R3 data" : "R2 data", 32'(rd_data), 32'(m_dout));
        chk(m_mode ? "R3 stat_a" : "R2 stat_a", 32'(stat_a), 32'(exp_a()));
        chk("R4 stat_b", 32'(stat_b), 32'(exp_b()));
        chk("R5 half_full", 32'(half_full), 32'(exp_hf()));
    endtask

    task automatic step(bit w, bit r, bit l, bit mk, bit rt, logic [DW-1:0] d);
        wr_en = w; rd_en = r; ld_en = l; mark = mk; retx = rt; wr_data = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset(bit mode);
        rst = 1'b1; fwft_sel = mode;
        step(0, 0, 1, 0, 0, '0);
        rst = 1'b0;
        phase = "R1";
        chk("R1 rd_data zero", 32'(rd_data), 32'h0);
        chk("R1 stat_a", 32'(stat_a), mode ? 32'h0 : 32'h1);
        chk("R1 stat_b", 32'(stat_b), mode ? 32'h1 : 32'h0);
    endtask

    task automatic directed(bit mode);
        do_reset(mode);
        phase = "R3 latency";
        step(1, 0, 1, 0, 0, 16'hA5A5);
        step(0, 0, 1, 0, 0, '0);
        if (mode) chk("R3 fall-through word", 32'(rd_data), 32'hA5A5);
        phase = "R7 fill";
        for (int i = 0; i < DEPTH + 3; i++) step(1, 0, 1, 0, 0, DW'(16'h100 + i));
        phase = "R6 ld low";
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 16'hDEAD);
        phase = "R10 drain";
        for (int i = 0; i < DEPTH + 4; i++) step(0, 1, 1, 0, 0, '0);
        phase = "R8 no mark";
        step(0, 0, 1, 0, 1, '0);
        step(0, 1, 1, 0, 1, '0);
        do_reset(mode);
        phase = "R8 replay";
        for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 0, DW'(16'h200 + i));
        step(0, 1, 1, 0, 0, '0);
        step(0, 0, 1, 1, 0, '0);
        for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 0, '0);
        step(0, 1, 1, 1, 1, '0);
        for (int i = 0; i < 6; i++) step(0, 1, 1, 0, 0, '0);
        phase = "R9 mark bound";
        for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 1, 0, 0, DW'(16'h300 + i));
        step(0, 1, 1, 0, 0, '0);
        step(1, 0, 1, 0, 0, 16'hBEEF);
        chk("R9 full held by mark", 32'(stat_b), mode ? 32'h0 : 32'h1);
        step(0, 0, 1, 0, 1, '0);
        for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 1, 0, 0, '0);
    endtask

    task automatic random_run(bit mode, int n);
        do_reset(mode);
        phase = "R10 random";
        for (int i = 0; i < n; i++) begin
            step(($urandom % 100) < 55, ($urandom % 100) < 45, ($urandom % 100) < 90,
                 ($urandom % 100) < 4, ($urandom % 100) < 4, DW'($urandom));
        end
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; fwft_sel = 0; ld_en = 0; wr_en = 0; rd_en = 0;
        mark = 0; retx = 0; wr_data = '0;
        @(negedge clk);
        directed(1'b0);
        directed(1'b1);
        random_run(1'b0, 3000);
        random_run(1'b1, 3000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule